// File: doc/BRIEF.md
# Switch-Selectable Baud Clock Generator

This block turns a fixed system clock into the sampling clock a UART needs, running at sixteen times the chosen baud rate. With a 2 MHz system clock, 9600 baud ideally needs 153.6 kHz. That is a ratio of about 13.02, so the first stage is an integer divide-by-13 prescaler. Each terminal count of the prescaler advances a short chain of binary halving stages. Each stage gives the next lower standard rate: 4800, 2400, 1200, 600 and 300 baud.

A static 3-bit rate select, normally wired to a DIP switch, picks which stage drives the output. The block drives a square-wave baud clock and a matching one-cycle enable strobe for logic that runs on the system clock. A new select value is held back until the prescaler wraps, so switching never produces a sliver of a pulse. The registered select sits between the prescaler and the stage multiplexer.

Top module: `baudgen_top`

## Requirements
- R1: Synchronous reset clears the prescaler and every halving stage. While reset is held and in the first cycle after it is released, baudClk and baudStb are low. The first prescaler terminal count then falls 12 cycles after release.
- R2: At select code 0, baudClk repeats every 13 system clocks. In each period it is low for the first 6 counts after the prescaler wraps and high for the remaining 7.
- R3: baudStb is high for one system clock per period of the selected tap. The period is 13·2^k clocks for tap k. The strobe falls in the last cycle of the tap's high phase, and every falling edge of baudClk at a steady select follows a strobe.
- R4: Select codes 1 to 5 give tap k = code, with period 13·2^k system clocks. The clock is high for the second half of each period, a 50 percent duty cycle.
- R5: Select codes 6 and 7 behave exactly like code 5, the 300-baud tap with period 416.
- R6: A change of select takes effect only at a prescaler terminal count. The tap sampled in the cycle the prescaler reads 12 drives the output from the next cycle on. The counters are not disturbed by the change.
- R7: baudStb is never high in two consecutive cycles, and it is high only while baudClk is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (2 MHz nominal) |
| rst | input | 1 | Synchronous reset, active high |
| rateSel | input | 3 | Rate select code: 0 = 9600 baud down to 5 = 300 baud; 6 and 7 also give 300 baud |
| baudClk | output | 1 | Square-wave clock at 16x the selected baud rate |
| baudStb | output | 1 | One-cycle enable, once per baudClk period |

## Verification
The bench sweeps every select code, including the two aliased codes, for at least two full periods of the slowest tap. It compares both outputs every cycle against a count-based formula. An off-by-one prescaler shows up as a drifting period, and a wrong high/low split shows up as a shifted phase at code 0. A strobe decoded on the wrong stage bits would fire at the wrong rate. Select changes are also made at arbitrary, non-aligned cycles. A design that applied the change at once, rather than at the next wrap, would diverge from the model in the cycles after each change. A reset in mid-run must bring the outputs low and restart the period count from zero.

// File: rtl/baudgen_pkg.sv
package baudgen_pkg;
  localparam int SEL_W = 3;

  // Strobes from the prescaler/select control into the divider datapath
  typedef struct packed {
    logic             clear;    // synchronous clear of the halving chain
    logic             tick;     // prescaler terminal count this cycle
    logic             preHigh;  // prescaler square-wave phase
    logic [SEL_W-1:0] sel;      // registered, clamped tap index
  } ctrl_t;
endpackage

// File: rtl/baudgen_ctrl.sv
module baudgen_ctrl
  import baudgen_pkg::*;
#(
  parameter int PRE_DIV  = 13,
  parameter int PRE_HIGH = 7,
  parameter int NUM_DIV  = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] rateSel,
  output ctrl_t            ctrlBus
);
  localparam int CNT_W   = $clog2(PRE_DIV);
  localparam int LAST    = PRE_DIV - 1;
  localparam int LOW_LEN = PRE_DIV - PRE_HIGH;

  logic [CNT_W-1:0] preCnt;
  logic [SEL_W-1:0] selReg;
  logic [SEL_W-1:0] selClamp;
  logic             termCnt;

  assign termCnt  = (preCnt == CNT_W'(LAST));
  assign selClamp = (rateSel > SEL_W'(NUM_DIV)) ? SEL_W'(NUM_DIV) : rateSel;

  always_ff @(posedge clk) begin
    if (rst) begin
      preCnt <= '0;
      selReg <= selClamp;
    end else if (termCnt) begin
      preCnt <= '0;
      selReg <= selClamp;
    end else begin
      preCnt <= preCnt + 1'b1;
    end
  end

  always_comb begin
    ctrlBus.clear   = rst;
    ctrlBus.tick    = termCnt;
    ctrlBus.preHigh = (preCnt >= CNT_W'(LOW_LEN));
    ctrlBus.sel     = selReg;
  end
endmodule

// File: rtl/baudgen_dp.sv
module baudgen_dp
  import baudgen_pkg::*;
#(
  parameter int NUM_DIV = 5
) (
  input  logic  clk,
  input  ctrl_t ctrlBus,
  output logic  baudClk,
  output logic  baudStb
);
  localparam int NUM_TAPS = NUM_DIV + 1;

  logic [NUM_DIV-1:0]  divCnt;
  logic [NUM_TAPS-1:0] tapClk;
  logic [NUM_TAPS-1:0] tapStb;

  always_ff @(posedge clk) begin
    if (ctrlBus.clear) divCnt <= '0;
    else if (ctrlBus.tick) divCnt <= divCnt + 1'b1;
  end

  for (genvar k = 0; k < NUM_TAPS; k++) begin : g_tap
    if (k == 0) begin : g_pre
      assign tapClk[k] = ctrlBus.preHigh;
      assign tapStb[k] = ctrlBus.tick;
    end else begin : g_half
      assign tapClk[k] = divCnt[k-1];
      assign tapStb[k] = ctrlBus.tick & (&divCnt[k-1:0]);
    end
  end

  assign baudClk = tapClk[ctrlBus.sel];
  assign baudStb = tapStb[ctrlBus.sel];
endmodule

// File: rtl/baudgen_top.sv
module baudgen_top
  import baudgen_pkg::*;
#(
  parameter int PRE_DIV  = 13,
  parameter int PRE_HIGH = 7,
  parameter int NUM_DIV  = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] rateSel,
  output logic             baudClk,
  output logic             baudStb
);
  ctrl_t            ctrlBus;
  logic             preTick;
  logic [SEL_W-1:0] selCur;

  baudgen_ctrl #(.PRE_DIV(PRE_DIV), .PRE_HIGH(PRE_HIGH), .NUM_DIV(NUM_DIV)) u_ctrl (
    .clk(clk), .rst(rst), .rateSel(rateSel), .ctrlBus(ctrlBus)
  );

  baudgen_dp #(.NUM_DIV(NUM_DIV)) u_dp (
    .clk(clk), .ctrlBus(ctrlBus), .baudClk(baudClk), .baudStb(baudStb)
  );

  assign preTick = ctrlBus.tick;
  assign selCur  = ctrlBus.sel;
endmodule

// File: rtl/baudgen_chk.sv
module baudgen_chk
  import baudgen_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             baudClk,
  input logic             baudStb,
  input logic             tick,
  input logic [SEL_W-1:0] selCur
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> (!baudClk && !baudStb));

  // R7
  strobe_single_chk: assert property (@(posedge clk) disable iff (rst) baudStb |=> !baudStb);

  // R7
  strobe_high_chk: assert property (@(posedge clk) disable iff (rst) baudStb |-> baudClk);

  // R6
  sel_switch_chk: assert property (@(posedge clk) disable iff (rst)
    (selCur != $past(selCur)) |-> $past(tick));

  // R3
  fall_after_stb_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(baudClk) && $stable(selCur)) |-> $past(baudStb));
endmodule

bind baudgen_top baudgen_chk u_chk (
  .clk(clk), .rst(rst), .baudClk(baudClk), .baudStb(baudStb),
  .tick(preTick), .selCur(selCur)
);

// File: tb/baudgen_top_bench.sv
module baudgen_top_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] rateSel = 3'd0;
  logic       baudClk;
  logic       baudStb;

  int n = 0;
  int expSel = 0;
  int rawSel = 0;
  int recent = 0;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  baudgen_top u_baudgen_top (
    .clk(clk), .rst(rst), .rateSel(rateSel), .baudClk(baudClk), .baudStb(baudStb)
  );

  function automatic int clampSel(int s);
    return (s > 5) ? 5 : s;
  endfunction

  function automatic logic modelClk(int k, int c);
    if (k == 0) return ((c % 13) >= 6);
    return logic'(((c / 13) >> (k - 1)) & 1);
  endfunction

  function automatic logic modelStb(int k, int c);
    return ((c % 13) == 12) && (((c / 13) % (1 << k)) == ((1 << k) - 1));
  endfunction

  task automatic check(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s cycle %0d sel %0d: actual %b expected %b", tag, n, rawSel, act, exp);
    end
  endtask

  task automatic compareNow();
    string tag;
    if (recent > 0) tag = "R6";
    else if (rawSel >= 6) tag = "R5";
    else if (expSel == 0) tag = "R2";
    else tag = "R4";
    check(tag, baudClk, modelClk(expSel, n));
    check((recent > 0) ? "R6" : "R3", baudStb, modelStb(expSel, n));
    // R7: strobe only during the high phase
    check("R7", baudStb & ~baudClk, 1'b0);
  endtask

  task automatic step();
    logic [2:0] selPrev;
    selPrev = rateSel;
    @(posedge clk);
    #1;
    n++;
    if (recent > 0) recent--;
    if (((n - 1) % 13) == 12) begin
      if (clampSel(int'(selPrev)) != expSel) recent = 40;
      expSel = clampSel(int'(selPrev));
      rawSel = int'(selPrev);
    end
    compareNow();
  endtask

  task automatic doReset(int s);
    rst = 1'b1;
    rateSel = 3'(s);
    repeat (3) begin
      @(posedge clk);
      #1;
      // R1: outputs quiet while reset is held
      check("R1", baudClk, 1'b0);
      check("R1", baudStb, 1'b0);
    end
    rst = 1'b0;
    n = 0;
    recent = 0;
    expSel = clampSel(s);
    rawSel = s;
    // R1: cleared state right after release
    check("R1", baudClk, 1'b0);
    check("R1", baudStb, 1'b0);
  endtask

  task automatic hold(int code, int cycles);
    rateSel = 3'(code);
    repeat (cycles) step();
  endtask

  initial begin
    doReset(0);
    // R1: first terminal count strobe 12 cycles after release
    repeat (11) step();
    check("R1", baudStb, 1'b0);
    step();
    check("R1", baudStb, 1'b1);
    // Full sweep over every code, unaligned switch points
    for (int c = 0; c < 8; c++) hold(c, 13 * 64 + 5);
    // Short holds in reverse order for many switches
    for (int c = 7; c >= 0; c--) hold(c, 13 * 3 + 7);
    for (int c = 0; c < 8; c++) hold((c * 5) % 8, 29);
    // Mid-run reset at a slow tap
    hold(3, 200);
    doReset(3);
    hold(3, 13 * 16);
    hold(6, 13 * 70);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule